// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts which loads must hold back behind an older in-flight store. A PC-indexed identifier table maps each instruction address to a small set number plus a valid flag. A second table, indexed by set number, remembers the newest dispatched store of each set that has not yet issued. When the load queue detects an ordering violation, it sends the load PC and the store PC. The identifier table then puts both instructions into one set.

A dispatch bundle of `NSLOT` instructions enters each cycle. Each slot looks up its set. Loads in a set that has a pending store get a wait bit and that store's tag. Stores record themselves as the newest member of their set and never receive a wait bit, so stores of one set can issue in any order. Writes to the set table land one cycle after the request, and a pending-write bypass hides that delay. A store earlier in the same bundle is also forwarded to a later load in that bundle. When a store issues, its set entry is dropped. The identifier table forgets everything at a fixed interval so that stale pairings age out.

Top module: `sset_pred`

## Requirements
- R1: The identifier table index is `pc[PC_LSB +: IDX_W]`. A load whose entry is invalid gets `out_wait`=0 and `out_dep_tag`=0. `out_dep_tag` is 0 for every slot whose `out_wait` is 0.
- R2: A violation on two PCs whose entries are both invalid gives both PCs a freshly allocated set. A later load at the load PC then waits on a store dispatched at the store PC.
- R3: When exactly one of the two PCs holds a valid set, the other PC adopts that set.
- R4: When both PCs hold valid sets, both take the numerically smaller set number. A store left in the larger set then no longer makes that load wait.
- R5: The result for the slots dispatched in cycle T appears on `out_vld`/`out_wait`/`out_dep_tag` in cycle T+2. `out_vld` equals `disp_vld` delayed by two cycles.
- R6: A store's set-table write becomes architectural one cycle after it leaves lookup. A load dispatched in the very next cycle still waits on that store, via the bypass.
- R7: Within one bundle, a store in a lower-numbered slot makes a later-slot load of the same set wait. A store in a higher-numbered slot than the load does not.
- R8: A store never has `out_wait` set, even if an older store of its set is pending.
- R9: The dependent tag is that of the newest store of the set. Within a bundle, the highest-numbered store slot is the newest.
- R10: An `iss_vld` pulse whose `iss_tag` matches the recorded store of a set clears that set's entry. Later loads of the set do not wait.
- R11: Every `CLEAR_INTERVAL` cycles after reset, all identifier-table entries become invalid, so pairs trained before the clear stop producing waits.
- R12: After reset, `out_vld`, `out_wait` and `out_dep_tag` are zero, and both tables are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld | input | NSLOT | Slot valid in the dispatch bundle |
| disp_st | input | NSLOT | Slot is a store (1) or a load (0) |
| disp_pc | input | NSLOT*PC_W | Instruction PC per slot |
| disp_tag | input | NSLOT*TAG_W | Store tag per slot (used for stores) |
| viol_vld | input | 1 | Violation training request |
| viol_ld_pc | input | PC_W | PC of the violating load |
| viol_st_pc | input | PC_W | PC of the store it bypassed |
| iss_vld | input | 1 | A store issued this cycle |
| iss_tag | input | TAG_W | Tag of the issued store |
| out_vld | output | NSLOT | Result valid per slot, two cycles after dispatch |
| out_wait | output | NSLOT | Load must wait on a store |
| out_dep_tag | output | NSLOT*TAG_W | Tag of the store to wait on |

## Verification
The bound checker watches four things on every cycle. Stores never get a wait bit. No tag appears without a wait. Result valids trail dispatch by exactly two cycles. The periodic clear pulses on its exact interval. Only the bench scenarios can show the training policy: allocation, adoption and the smaller-number merge. They also cover each forwarding path (same bundle, pending write, settled table), newest-store selection, invalidation on issue, and the loss of pairings after a clear, since each needs a multi-cycle history of training and dispatch.

// File: rtl/sset_pkg.sv
package sset_pkg;

  typedef enum logic [1:0] {
    TR_ALLOC   = 2'd0,
    TR_TAKE_ST = 2'd1,
    TR_TAKE_LD = 2'd2,
    TR_MERGE   = 2'd3
  } train_act_e;

  function automatic train_act_e classify(input logic ld_valid, input logic st_valid);
    if (ld_valid && st_valid) return TR_MERGE;
    if (st_valid)             return TR_TAKE_ST;
    if (ld_valid)             return TR_TAKE_LD;
    return TR_ALLOC;
  endfunction

endpackage

// File: rtl/sset_ssit.sv
module sset_ssit #(
  parameter int PC_W           = 16,
  parameter int PC_LSB         = 1,
  parameter int IDX_W          = 6,
  parameter int SSID_W         = 4,
  parameter int NSLOT          = 2,
  parameter int CLEAR_INTERVAL = 131072
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOT*PC_W-1:0]   lk_pc,
  output logic [NSLOT-1:0]        rd_vld,
  output logic [NSLOT*SSID_W-1:0] rd_id,
  input  logic                    tr_vld,
  input  logic [PC_W-1:0]         tr_ld_pc,
  input  logic [PC_W-1:0]         tr_st_pc,
  output logic                    clr_pulse
);
  import sset_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(CLEAR_INTERVAL);

  logic [DEPTH-1:0]  vld_q;
  logic [SSID_W-1:0] id_mem [DEPTH];
  logic [SSID_W-1:0] alloc_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[PC_LSB +: IDX_W];
  endfunction

  // periodic aging
  assign clr_pulse = (cnt_q == CNT_W'(CLEAR_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_pulse) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // training decision
  logic [IDX_W-1:0]  li, si;
  logic [SSID_W-1:0] lid, sid, new_id;
  train_act_e        act;

  always_comb begin
    li  = idx_of(tr_ld_pc);
    si  = idx_of(tr_st_pc);
    lid = id_mem[li];
    sid = id_mem[si];
    act = classify(vld_q[li], vld_q[si]);
    case (act)
      TR_TAKE_ST: new_id = sid;
      TR_TAKE_LD: new_id = lid;
      TR_MERGE:   new_id = (lid < sid) ? lid : sid;
      default:    new_id = alloc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tr_vld) begin
      id_mem[li] <= new_id;
      id_mem[si] <= new_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_pulse) begin
      vld_q <= '0;
    end else if (tr_vld) begin
      vld_q[li] <= 1'b1;
      vld_q[si] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                           alloc_q <= '0;
    else if (tr_vld && act == TR_ALLOC) alloc_q <= alloc_q + 1'b1;
  end

  // registered lookup ports
  always_ff @(posedge clk) begin
    for (int s = 0; s < NSLOT; s++) begin
      rd_id[s*SSID_W +: SSID_W] <= id_mem[idx_of(lk_pc[s*PC_W +: PC_W])];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= '0;
    else begin
      for (int s = 0; s < NSLOT; s++) begin
        rd_vld[s] <= vld_q[idx_of(lk_pc[s*PC_W +: PC_W])] && !clr_pulse;
      end
    end
  end

endmodule

// File: rtl/sset_lfst.sv
module sset_lfst #(
  parameter int SSID_W = 4,
  parameter int TAG_W  = 6,
  parameter int NSLOT  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOT-1:0]        wr_vld,
  input  logic [NSLOT*SSID_W-1:0] wr_id,
  input  logic [NSLOT*TAG_W-1:0]  wr_tag,
  input  logic                    iss_vld,
  input  logic [TAG_W-1:0]        iss_tag,
  input  logic [NSLOT*SSID_W-1:0] rd_id,
  output logic [NSLOT-1:0]        rd_hit,
  output logic [NSLOT*TAG_W-1:0]  rd_tag
);

  localparam int NSETS = 1 << SSID_W;

  logic [NSLOT-1:0]  pend_vld_q;
  logic [SSID_W-1:0] pend_id_q  [NSLOT];
  logic [TAG_W-1:0]  pend_tag_q [NSLOT];
  logic [NSETS-1:0]  ent_vld_q;
  logic [TAG_W-1:0]  ent_tag_q  [NSETS];

  // one-cycle delay stage for writes
  always_ff @(posedge clk) begin
    if (rst) pend_vld_q <= '0;
    else     pend_vld_q <= wr_vld;
    for (int k = 0; k < NSLOT; k++) begin
      pend_id_q[k]  <= wr_id[k*SSID_W +: SSID_W];
      pend_tag_q[k] <= wr_tag[k*TAG_W +: TAG_W];
    end
  end

  // table update: pending write beats issue-invalidate, unless that store issued
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld_q <= '0;
    end else begin
      for (int e = 0; e < NSETS; e++) begin
        if (iss_vld && ent_vld_q[e] && ent_tag_q[e] == iss_tag) ent_vld_q[e] <= 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
          if (pend_vld_q[k] && pend_id_q[k] == SSID_W'(e) &&
              !(iss_vld && pend_tag_q[k] == iss_tag)) begin
            ent_vld_q[e] <= 1'b1;
            ent_tag_q[e] <= pend_tag_q[k];
          end
        end
      end
    end
  end

  // read with bypass of the pending writes (highest slot newest)
  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      logic [SSID_W-1:0] id;
      id = rd_id[s*SSID_W +: SSID_W];
      rd_hit[s]                 = ent_vld_q[id];
      rd_tag[s*TAG_W +: TAG_W]  = ent_tag_q[id];
      for (int k = 0; k < NSLOT; k++) begin
        if (pend_vld_q[k] && pend_id_q[k] == id) begin
          rd_hit[s]                = 1'b1;
          rd_tag[s*TAG_W +: TAG_W] = pend_tag_q[k];
        end
      end
    end
  end

endmodule

// File: rtl/sset_bundle_fwd.sv
module sset_bundle_fwd #(
  parameter int SSID_W = 4,
  parameter int TAG_W  = 6,
  parameter int NSLOT  = 2
) (
  input  logic [NSLOT-1:0]        s_vld,
  input  logic [NSLOT-1:0]        s_st,
  input  logic [NSLOT-1:0]        s_hit,
  input  logic [NSLOT*SSID_W-1:0] s_id,
  input  logic [NSLOT*TAG_W-1:0]  s_tag,
  input  logic [NSLOT-1:0]        lf_hit,
  input  logic [NSLOT*TAG_W-1:0]  lf_tag,
  output logic [NSLOT-1:0]        res_wait,
  output logic [NSLOT*TAG_W-1:0]  res_tag
);

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      logic             byp;
      logic [TAG_W-1:0] bt;
      logic             is_ld;
      byp = 1'b0;
      bt  = '0;
      for (int j = 0; j < NSLOT; j++) begin
        if (j < i && s_vld[j] && s_st[j] && s_hit[j] &&
            s_id[j*SSID_W +: SSID_W] == s_id[i*SSID_W +: SSID_W]) begin
          byp = 1'b1;
          bt  = s_tag[j*TAG_W +: TAG_W];
        end
      end
      is_ld       = s_vld[i] && !s_st[i] && s_hit[i];
      res_wait[i] = is_ld && (byp || lf_hit[i]);
      if (!res_wait[i])  res_tag[i*TAG_W +: TAG_W] = '0;
      else if (byp)      res_tag[i*TAG_W +: TAG_W] = bt;
      else               res_tag[i*TAG_W +: TAG_W] = lf_tag[i*TAG_W +: TAG_W];
    end
  end

endmodule

// File: rtl/sset_pred.sv
module sset_pred #(
  parameter int NSLOT          = 2,
  parameter int PC_W           = 16,
  parameter int PC_LSB         = 1,
  parameter int IDX_W          = 6,
  parameter int SSID_W         = 4,
  parameter int TAG_W          = 6,
  parameter int CLEAR_INTERVAL = 131072
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSLOT-1:0]       disp_vld,
  input  logic [NSLOT-1:0]       disp_st,
  input  logic [NSLOT*PC_W-1:0]  disp_pc,
  input  logic [NSLOT*TAG_W-1:0] disp_tag,
  input  logic                   viol_vld,
  input  logic [PC_W-1:0]        viol_ld_pc,
  input  logic [PC_W-1:0]        viol_st_pc,
  input  logic                   iss_vld,
  input  logic [TAG_W-1:0]       iss_tag,
  output logic [NSLOT-1:0]       out_vld,
  output logic [NSLOT-1:0]       out_wait,
  output logic [NSLOT*TAG_W-1:0] out_dep_tag
);

  logic [NSLOT-1:0]        s1_vld, s1_st;
  logic [NSLOT*TAG_W-1:0]  s1_tag;
  logic [NSLOT-1:0]        s1_hit;
  logic [NSLOT*SSID_W-1:0] s1_id;
  logic [NSLOT-1:0]        lf_hit;
  logic [NSLOT*TAG_W-1:0]  lf_tag;
  logic [NSLOT-1:0]        st_wr;
  logic [NSLOT-1:0]        res_wait;
  logic [NSLOT*TAG_W-1:0]  res_tag;
  logic                    clr_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= '0;
      s1_st  <= '0;
    end else begin
      s1_vld <= disp_vld;
      s1_st  <= disp_st;
    end
    s1_tag <= disp_tag;
  end

  sset_ssit #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .SSID_W(SSID_W),
    .NSLOT(NSLOT), .CLEAR_INTERVAL(CLEAR_INTERVAL)
  ) u_ssit (
    .clk(clk), .rst(rst),
    .lk_pc(disp_pc), .rd_vld(s1_hit), .rd_id(s1_id),
    .tr_vld(viol_vld), .tr_ld_pc(viol_ld_pc), .tr_st_pc(viol_st_pc),
    .clr_pulse(clr_pulse)
  );

  assign st_wr = s1_vld & s1_st & s1_hit;

  sset_lfst #(.SSID_W(SSID_W), .TAG_W(TAG_W), .NSLOT(NSLOT)) u_lfst (
    .clk(clk), .rst(rst),
    .wr_vld(st_wr), .wr_id(s1_id), .wr_tag(s1_tag),
    .iss_vld(iss_vld), .iss_tag(iss_tag),
    .rd_id(s1_id), .rd_hit(lf_hit), .rd_tag(lf_tag)
  );

  sset_bundle_fwd #(.SSID_W(SSID_W), .TAG_W(TAG_W), .NSLOT(NSLOT)) u_fwd (
    .s_vld(s1_vld), .s_st(s1_st), .s_hit(s1_hit), .s_id(s1_id), .s_tag(s1_tag),
    .lf_hit(lf_hit), .lf_tag(lf_tag),
    .res_wait(res_wait), .res_tag(res_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= '0;
      out_wait    <= '0;
      out_dep_tag <= '0;
    end else begin
      out_vld     <= s1_vld;
      out_wait    <= res_wait;
      out_dep_tag <= res_tag;
    end
  end

endmodule

// File: rtl/sset_pred_chk.sv
module sset_pred_chk #(
  parameter int NSLOT          = 2,
  parameter int TAG_W          = 6,
  parameter int CLEAR_INTERVAL = 131072
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NSLOT-1:0]       disp_vld,
  input logic [NSLOT-1:0]       disp_st,
  input logic [NSLOT-1:0]       out_vld,
  input logic [NSLOT-1:0]       out_wait,
  input logic [NSLOT*TAG_W-1:0] out_dep_tag,
  input logic                   clr_pulse
);
  localparam int CNT_W = $clog2(CLEAR_INTERVAL);

  logic [NSLOT-1:0] v1, v2, st1, st2;
  logic [CNT_W-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= '0; v2 <= '0; st1 <= '0; st2 <= '0;
    end else begin
      v1 <= disp_vld; v2 <= v1; st1 <= disp_st; st2 <= st1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                         cyc_q <= '0;
    else if (cyc_q == CNT_W'(CLEAR_INTERVAL - 1))    cyc_q <= '0;
    else                                             cyc_q <= cyc_q + 1'b1;
  end

  // R5
  vld_delay_chk: assert property (@(posedge clk) disable iff (rst) out_vld == v2);

  // R8
  store_nowait_chk: assert property (@(posedge clk) disable iff (rst) (out_wait & st2 & v2) == '0);

  // R12
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_vld == '0 && out_wait == '0 && out_dep_tag == '0));

  // R11
  clear_period_chk: assert property (@(posedge clk) disable iff (rst)
    clr_pulse == (cyc_q == CNT_W'(CLEAR_INTERVAL - 1)));

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      // R1
      tag_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_wait[g] |-> out_dep_tag[g*TAG_W +: TAG_W] == '0);
    end
  endgenerate

endmodule

bind sset_pred sset_pred_chk #(
  .NSLOT(NSLOT), .TAG_W(TAG_W), .CLEAR_INTERVAL(CLEAR_INTERVAL)
) u_chk (
  .clk(clk), .rst(rst), .disp_vld(disp_vld), .disp_st(disp_st),
  .out_vld(out_vld), .out_wait(out_wait), .out_dep_tag(out_dep_tag),
  .clr_pulse(clr_pulse)
);

// File: tb/sset_pred_test.sv
`timescale 1ns/1ps
module sset_pred_test;
  localparam int NSLOT = 2;
  localparam int PC_W  = 16;
  localparam int TAG_W = 6;
  localparam int CLR   = 2048;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [NSLOT-1:0]       disp_vld = '0, disp_st = '0;
  logic [NSLOT*PC_W-1:0]  disp_pc = '0;
  logic [NSLOT*TAG_W-1:0] disp_tag = '0;
  logic                   viol_vld = 1'b0;
  logic [PC_W-1:0]        viol_ld_pc = '0, viol_st_pc = '0;
  logic                   iss_vld = 1'b0;
  logic [TAG_W-1:0]       iss_tag = '0;
  logic [NSLOT-1:0]       out_vld, out_wait;
  logic [NSLOT*TAG_W-1:0] out_dep_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sset_pred #(.NSLOT(NSLOT), .PC_W(PC_W), .TAG_W(TAG_W), .CLEAR_INTERVAL(CLR)) uut (
    .clk(clk), .rst(rst), .disp_vld(disp_vld), .disp_st(disp_st), .disp_pc(disp_pc),
    .disp_tag(disp_tag), .viol_vld(viol_vld), .viol_ld_pc(viol_ld_pc),
    .viol_st_pc(viol_st_pc), .iss_vld(iss_vld), .iss_tag(iss_tag),
    .out_vld(out_vld), .out_wait(out_wait), .out_dep_tag(out_dep_tag)
  );

  // {ld idx(6), st idx(6), train, gap(2), load-in-lower-slot, expected wait}
  localparam logic [16:0] VEC [6] = '{
    {6'd1,  6'd2,  1'b1, 2'd0, 1'b0, 1'b1},  // R7 same bundle, store first
    {6'd3,  6'd4,  1'b1, 2'd1, 1'b0, 1'b1},  // R6 pending-write bypass
    {6'd5,  6'd6,  1'b1, 2'd2, 1'b0, 1'b1},  // R2 settled table
    {6'd7,  6'd8,  1'b1, 2'd0, 1'b1, 1'b0},  // R7 load ahead of store
    {6'd9,  6'd10, 1'b0, 2'd1, 1'b0, 1'b0},  // R1 untrained
    {6'd11, 6'd12, 1'b1, 2'd3, 1'b0, 1'b1}   // R2 longer gap
  };

  function automatic logic [PC_W-1:0] pc_of(input int idx);
    return PC_W'(idx << 1);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic v0, input logic s0, input logic [PC_W-1:0] p0,
                       input logic [TAG_W-1:0] t0, input logic v1, input logic s1,
                       input logic [PC_W-1:0] p1, input logic [TAG_W-1:0] t1);
    disp_vld = {v1, v0};
    disp_st  = {s1, s0};
    disp_pc  = {p1, p0};
    disp_tag = {t1, t0};
    @(negedge clk);
    disp_vld = '0; disp_st = '0; disp_pc = '0; disp_tag = '0;
  endtask

  task automatic train(input int ld, input int st);
    viol_vld = 1'b1; viol_ld_pc = pc_of(ld); viol_st_pc = pc_of(st);
    @(negedge clk);
    viol_vld = 1'b0;
    idle(2);
  endtask

  task automatic issue(input logic [TAG_W-1:0] t);
    iss_vld = 1'b1; iss_tag = t;
    @(negedge clk);
    iss_vld = 1'b0;
    idle(2);
  endtask

  task automatic slot_chk(input string req, input int slot, input int ew, input int et);
    chk({req, " valid"}, int'(out_vld[slot]), 1);
    chk({req, " wait"}, int'(out_wait[slot]), ew);
    chk({req, " tag"}, int'(out_dep_tag[slot*TAG_W +: TAG_W]), et);
  endtask

  // store at slot0, load at slot0 gap cycles later; sampled two cycles after the load
  task automatic st_then_ld(input string req, input int st, input int t, input int ld,
                            input int gap, input int ew, input int et);
    drive(1'b1, 1'b1, pc_of(st), TAG_W'(t), 1'b0, 1'b0, '0, '0);
    idle(gap - 1);
    drive(1'b1, 1'b0, pc_of(ld), '0, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    slot_chk(req, 0, ew, et);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 out_vld", int'(out_vld), 0);
    chk("R12 out_wait", int'(out_wait), 0);
    chk("R12 out_dep_tag", int'(out_dep_tag), 0);

    for (int k = 0; k < 6; k++) begin
      logic [16:0] v;
      int ld, st, gap, t, ew, slot;
      v   = VEC[k];
      ld  = int'(v[16:11]);
      st  = int'(v[10:5]);
      gap = int'(v[3:2]);
      ew  = int'(v[0]);
      t   = 40 + k;
      if (v[4]) train(ld, st);
      if (gap == 0) begin
        if (v[1]) drive(1'b1, 1'b0, pc_of(ld), '0, 1'b1, 1'b1, pc_of(st), TAG_W'(t));
        else      drive(1'b1, 1'b1, pc_of(st), TAG_W'(t), 1'b1, 1'b0, pc_of(ld), '0);
        @(negedge clk);
        slot = v[1] ? 0 : 1;
        slot_chk("R7/R2 vector", slot, ew, ew != 0 ? t : 0);
      end else begin
        st_then_ld("R6/R2/R1 vector", st, t, ld, gap, ew, ew != 0 ? t : 0);
      end
      issue(TAG_W'(t));
    end

    // R4 merge to the smaller set
    train(20, 21);
    train(22, 23);
    train(22, 21);
    st_then_ld("R4 merged", 21, 30, 22, 2, 1, 30);
    issue(6'd30);
    st_then_ld("R4 old set", 23, 31, 22, 2, 0, 0);
    issue(6'd31);

    // R3 adoption of the existing set
    train(24, 21);
    st_then_ld("R3 adopt", 21, 9, 24, 2, 1, 9);
    issue(6'd9);

    // R8 stores never wait; R9 highest slot is newest
    drive(1'b1, 1'b1, pc_of(21), 6'd10, 1'b1, 1'b1, pc_of(21), 6'd11);
    @(negedge clk);
    chk("R8 store slot1 wait", int'(out_wait[1]), 0);
    chk("R8 store slot0 wait", int'(out_wait[0]), 0);
    drive(1'b1, 1'b0, pc_of(20), '0, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    slot_chk("R9 newest", 0, 1, 11);
    issue(6'd11);

    // R10 issue clears the entry
    drive(1'b1, 1'b1, pc_of(21), 6'd12, 1'b0, 1'b0, '0, '0);
    idle(3);
    issue(6'd12);
    drive(1'b1, 1'b0, pc_of(20), '0, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    slot_chk("R10 after issue", 0, 0, 0);

    // R11 periodic clear
    idle(CLR + 50);
    st_then_ld("R11 after clear", 21, 15, 20, 2, 0, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule